// File: doc/BRIEF.md
# Combinational ALU with Error Code

This block is a stateless arithmetic-logic unit for a 32-bit datapath. A 4-bit select picks one of twelve operations on two operands. The unit drives a 32-bit result and a 4-bit error code that tells overflow, underflow and division by zero apart. The result and the error code depend only on the present inputs. There is no clock, no reset and no storage. When an input changes, the outputs follow within the same time step.

Inside, the work is split across three units that run in parallel:

- an add/subtract unit, shared by the unsigned and two's complement forms;
- a multiply/divide unit;
- a logic unit for the whole-word truth operations and the bitwise operations.

The top module picks one of their outputs with a single complete case over the select. It has no states and no transitions. The select values 12 to 15 lead to a fixed all-zero output with no error.

For subtract and divide, operand A is always the left-hand operand and operand B the right-hand operand. Every arithmetic result wraps to 32 bits. The error code records when the true value did not fit.

Top module: `alu_top`

## Requirements
- R1: Select 0 (unsigned add) gives (A+B) mod 2^32. The error code is 1 (overflow) when the true sum exceeds 2^32-1, and 0 otherwise.
- R2: Select 1 (unsigned subtract) gives (A-B) mod 2^32. The error code is 2 (underflow) when B > A as unsigned values, and 0 otherwise.
- R3: Select 2 (signed add) gives the wrapped two's complement sum. The error code is 1 when the true sum is above 2^31-1, 2 when it is below -2^31, and 0 otherwise.
- R4: Select 3 (signed subtract) gives the wrapped value of A-B. It reports 1 or 2 under the same range rule as R3.
- R5: Select 4 (signed multiply) gives the low 32 bits of the 64-bit signed product. When the product does not fit in 32 signed bits, the error code is 1 for a positive product and 2 for a negative one.
- R6: Select 5 (signed divide) with B nonzero gives A/B truncated toward zero. The one case that does not fit is -2^31 / -1, which reports error 1 with result 0x80000000.
- R7: Select 5 with B equal to zero gives result 0 and error code 3.
- R8: Selects 6 (logical AND) and 8 (logical OR) treat any nonzero operand as true. They return 1 for true and 0 for false.
- R9: Selects 7 and 9 return the bitwise AND and the bitwise OR of A and B.
- R10: Select 10 returns 1 when A is zero and 0 otherwise. Select 11 returns the bitwise complement of A. B has no effect on either result.
- R11: Selects 12 to 15 return result 0 with error code 0.
- R12: Every select from 6 to 11 returns error code 0.
- R13: Both outputs follow a change on any input with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | Left-hand operand |
| op_b | input | 32 | Right-hand operand (ignored by selects 10 and 11) |
| op_sel | input | 4 | Operation select |
| result | output | 32 | Result of the selected operation |
| err_code | output | 4 | 0 none, 1 overflow, 2 underflow, 3 divide by zero |

## Verification
Immediate assertions re-check a set of relations each time the inputs change:

- the reserved selects give a zero result and no error (R11);
- the logic selects give no error, and the whole-word truth selects return only 0 or 1 (R8, R12);
- division by zero gives result 0 and error 3 (R7);
- an unsigned add with no error returns a result no smaller than A (R1);
- the unsigned subtract's underflow flag matches B > A (R2).

These relations cannot show whether a sum, product or quotient has the right value, where the signed range limits fall, or that B leaves the NOT results alone. Those points come only from the bench scenarios. In them, a 64-bit reference model computes the expected values for random and directed operand pairs, such as the extreme values, -2^31 / -1 and differing values of B under the NOT selects.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned SEL_W  = 4;
    localparam int unsigned ERR_W  = 4;

    typedef enum logic [SEL_W-1:0] {
        SEL_UADD  = 4'd0,
        SEL_USUB  = 4'd1,
        SEL_SADD  = 4'd2,
        SEL_SSUB  = 4'd3,
        SEL_SMUL  = 4'd4,
        SEL_SDIV  = 4'd5,
        SEL_LAND  = 4'd6,
        SEL_BAND  = 4'd7,
        SEL_LOR   = 4'd8,
        SEL_BOR   = 4'd9,
        SEL_LNOT  = 4'd10,
        SEL_BNOT  = 4'd11,
        SEL_RSV0  = 4'd12,
        SEL_RSV1  = 4'd13,
        SEL_RSV2  = 4'd14,
        SEL_RSV3  = 4'd15
    } alu_sel_e;

    typedef enum logic [ERR_W-1:0] {
        ERR_NONE = 4'd0,
        ERR_OVF  = 4'd1,
        ERR_UNF  = 4'd2,
        ERR_DIV0 = 4'd3
    } alu_err_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    input  logic         is_signed,
    output logic [W-1:0] sum,
    output alu_err_e     err
);

    logic [W:0] wide;
    logic       sign_a;
    logic       sign_b;
    logic       sign_r;
    logic       sgn_bad;

    always_comb begin
        if (do_sub) begin
            wide = {1'b0, a} - {1'b0, b};
        end else begin
            wide = {1'b0, a} + {1'b0, b};
        end
        sum    = wide[W-1:0];
        sign_a = a[W-1];
        sign_b = b[W-1];
        sign_r = wide[W-1];
        if (do_sub) begin
            sgn_bad = (sign_a != sign_b) && (sign_r != sign_a);
        end else begin
            sgn_bad = (sign_a == sign_b) && (sign_r != sign_a);
        end
    end

    always_comb begin
        err = ERR_NONE;
        if (is_signed) begin
            if (sgn_bad) begin
                err = sign_a ? ERR_UNF : ERR_OVF;
            end
        end else if (wide[W]) begin
            err = do_sub ? ERR_UNF : ERR_OVF;
        end
    end

    always_comb begin
        if (do_sub && !is_signed) begin
            // R2
            usub_borrow_chk: assert ((err == ERR_UNF) == (b > a));
        end
    end

endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv
    import alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] mul_res,
    output alu_err_e     mul_err,
    output logic [W-1:0] div_res,
    output alu_err_e     div_err
);

    localparam int unsigned PW = 2 * W;

    logic [PW-1:0] prod;
    logic [W:0]    top_bits;
    logic          fits;

    always_comb begin
        prod     = {{W{a[W-1]}}, a} * {{W{b[W-1]}}, b};
        mul_res  = prod[W-1:0];
        top_bits = prod[PW-1:W-1];
        fits     = (&top_bits) || (~|top_bits);
        if (fits) begin
            mul_err = ERR_NONE;
        end else begin
            mul_err = prod[PW-1] ? ERR_UNF : ERR_OVF;
        end
    end

    logic [W-1:0] mag_a;
    logic [W-1:0] mag_b;
    logic [W-1:0] mag_b_safe;
    logic [W-1:0] mag_q;
    logic         q_neg;
    logic         b_zero;

    always_comb begin
        mag_a      = a[W-1] ? (~a + 1'b1) : a;
        mag_b      = b[W-1] ? (~b + 1'b1) : b;
        b_zero     = (b == '0);
        mag_b_safe = b_zero ? {{(W-1){1'b0}}, 1'b1} : mag_b;
        mag_q      = mag_a / mag_b_safe;
        q_neg      = a[W-1] ^ b[W-1];
        if (b_zero) begin
            div_res = '0;
            div_err = ERR_DIV0;
        end else begin
            div_res = q_neg ? (~mag_q + 1'b1) : mag_q;
            div_err = (!q_neg && mag_q[W-1]) ? ERR_OVF : ERR_NONE;
        end
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_sel_e     sel,
    output logic [W-1:0] res
);

    localparam logic [W-1:0] TRUE_W = {{(W-1){1'b0}}, 1'b1};

    logic a_true;
    logic b_true;

    always_comb begin
        a_true = |a;
        b_true = |b;
        unique case (sel)
            SEL_LAND: res = (a_true && b_true) ? TRUE_W : '0;
            SEL_LOR:  res = (a_true || b_true) ? TRUE_W : '0;
            SEL_LNOT: res = a_true ? '0 : TRUE_W;
            SEL_BAND: res = a & b;
            SEL_BOR:  res = a | b;
            SEL_BNOT: res = ~a;
            default:  res = '0;
        endcase
    end

endmodule

// File: rtl/alu_top.sv
module alu_top
    import alu_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    input  logic [SEL_W-1:0] op_sel,
    output logic [W-1:0]     result,
    output logic [ERR_W-1:0] err_code
);

    alu_sel_e     sel;
    logic         as_sub;
    logic         as_signed;
    logic [W-1:0] as_sum;
    alu_err_e     as_err;
    logic [W-1:0] mul_res;
    alu_err_e     mul_err;
    logic [W-1:0] div_res;
    alu_err_e     div_err;
    logic [W-1:0] lg_res;

    always_comb begin
        sel       = alu_sel_e'(op_sel);
        as_sub    = (sel == SEL_USUB) || (sel == SEL_SSUB);
        as_signed = (sel == SEL_SADD) || (sel == SEL_SSUB);
    end

    alu_addsub #(.W(W)) u_addsub (
        .a         (op_a),
        .b         (op_b),
        .do_sub    (as_sub),
        .is_signed (as_signed),
        .sum       (as_sum),
        .err       (as_err)
    );

    alu_muldiv #(.W(W)) u_muldiv (
        .a       (op_a),
        .b       (op_b),
        .mul_res (mul_res),
        .mul_err (mul_err),
        .div_res (div_res),
        .div_err (div_err)
    );

    alu_logic #(.W(W)) u_logic (
        .a   (op_a),
        .b   (op_b),
        .sel (sel),
        .res (lg_res)
    );

    always_comb begin
        unique case (sel)
            SEL_UADD, SEL_USUB, SEL_SADD, SEL_SSUB: begin
                result   = as_sum;
                err_code = as_err;
            end
            SEL_SMUL: begin
                result   = mul_res;
                err_code = mul_err;
            end
            SEL_SDIV: begin
                result   = div_res;
                err_code = div_err;
            end
            SEL_LAND, SEL_BAND, SEL_LOR, SEL_BOR, SEL_LNOT, SEL_BNOT: begin
                result   = lg_res;
                err_code = ERR_NONE;
            end
            SEL_RSV0, SEL_RSV1, SEL_RSV2, SEL_RSV3: begin
                result   = '0;
                err_code = ERR_NONE;
            end
        endcase
    end

    always_comb begin
        if (op_sel >= 4'd12) begin
            // R11
            reserved_zero_chk: assert (result == '0 && err_code == ERR_NONE);
        end
        if (op_sel >= 4'd6 && op_sel <= 4'd11) begin
            // R12
            logic_no_err_chk: assert (err_code == ERR_NONE);
        end
        if (op_sel == 4'd6 || op_sel == 4'd8 || op_sel == 4'd10) begin
            // R8
            truth_range_chk: assert (result <= W'(1));
        end
        if (op_sel == 4'd5 && op_b == '0) begin
            // R7
            div_zero_chk: assert (result == '0 && err_code == ERR_DIV0);
        end
        if (op_sel == 4'd0 && err_code == ERR_NONE) begin
            // R1
            uadd_nowrap_chk: assert (result >= op_a);
        end
    end

endmodule

// File: tb/alu_top_test.sv
module alu_top_test;

    logic        clk = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [3:0]  op_sel = '0;
    logic [31:0] result;
    logic [3:0]  err_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    localparam longint SMAX = 64'sd2147483647;
    localparam longint SMIN = -64'sd2147483648;

    always #5ns clk = ~clk;

    alu_top uut (
        .op_a     (op_a),
        .op_b     (op_b),
        .op_sel   (op_sel),
        .result   (result),
        .err_code (err_code)
    );

    function automatic logic [3:0] range_err(input longint t);
        if (t > SMAX) return 4'd1;
        if (t < SMIN) return 4'd2;
        return 4'd0;
    endfunction

    function automatic void model(input logic [3:0] s, input logic [31:0] a,
                                  input logic [31:0] b,
                                  output logic [31:0] r, output logic [3:0] e);
        longint sa, sb, ua, ub, t;
        sa = $signed(a);
        sb = $signed(b);
        ua = {32'b0, a};
        ub = {32'b0, b};
        e  = 4'd0;
        r  = '0;
        case (s)
            4'd0: begin t = ua + ub; r = t[31:0]; e = (t > 64'sd4294967295) ? 4'd1 : 4'd0; end
            4'd1: begin t = ua - ub; r = t[31:0]; e = (ub > ua) ? 4'd2 : 4'd0; end
            4'd2: begin t = sa + sb; r = t[31:0]; e = range_err(t); end
            4'd3: begin t = sa - sb; r = t[31:0]; e = range_err(t); end
            4'd4: begin t = sa * sb; r = t[31:0]; e = range_err(t); end
            4'd5: begin
                if (b == '0) begin r = '0; e = 4'd3; end
                else begin t = sa / sb; r = t[31:0]; e = range_err(t); end
            end
            4'd6:  r = (a != 0 && b != 0) ? 32'd1 : 32'd0;
            4'd7:  r = a & b;
            4'd8:  r = (a != 0 || b != 0) ? 32'd1 : 32'd0;
            4'd9:  r = a | b;
            4'd10: r = (a == 0) ? 32'd1 : 32'd0;
            4'd11: r = ~a;
            default: r = '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] s, input logic [31:0] b);
        case (s)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return (b == 0) ? "R7" : "R6";
            4'd6, 4'd8: return "R8";
            4'd7, 4'd9: return "R9";
            4'd10, 4'd11: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act_r,
                         input logic [31:0] exp_r, input logic [3:0] act_e,
                         input logic [3:0] exp_e);
        n_checks++;
        if (act_r !== exp_r || act_e !== exp_e) begin
            n_fail++;
            $display("FAIL %s sel=%0d a=%h b=%h: result %h err %0d, expected %h err %0d",
                     tag, op_sel, op_a, op_b, act_r, act_e, exp_r, exp_e);
        end
    endtask

    task automatic apply(input logic [3:0] s, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] er;
        logic [3:0]  ee;
        string       tg;
        @(negedge clk);
        op_sel = s;
        op_a   = a;
        op_b   = b;
        #1ns;
        model(s, a, b, er, ee);
        tg = tag_of(s, b);
        check(tg, result, er, err_code, ee);
        if (s >= 4'd6 && s <= 4'd11) begin
            // R12: logic selects never flag an error
            check("R12", result, er, err_code, 4'd0);
        end
    endtask

    function automatic logic [31:0] pick_operand();
        case ($urandom % 6)
            0: return $urandom % 8;
            1: return 32'h7fffffff - ($urandom % 4);
            2: return 32'h80000000 + ($urandom % 4);
            3: return 32'hffffffff - ($urandom % 4);
            default: return $urandom;
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20240613));
        @(negedge clk);
        #1ns;
        // reset-free start: all-zero inputs select unsigned add of zeros (R1)
        check("R1", result, 32'd0, err_code, 4'd0);

        apply(4'd0, 32'hffffffff, 32'd1);
        apply(4'd0, 32'd5, 32'd7);
        apply(4'd1, 32'd3, 32'd5);
        apply(4'd1, 32'd9, 32'd9);
        apply(4'd2, 32'h7fffffff, 32'd1);
        apply(4'd2, 32'h80000000, 32'hffffffff);
        apply(4'd3, 32'h80000000, 32'd1);
        apply(4'd3, 32'h7fffffff, 32'hffffffff);
        apply(4'd3, 32'd10, 32'd3);
        apply(4'd4, 32'h00010000, 32'h00010000);
        apply(4'd4, 32'h00010000, 32'hffff0000);
        apply(4'd4, 32'hfffffffd, 32'd7);
        apply(4'd5, 32'h80000000, 32'hffffffff);
        apply(4'd5, 32'hfffffff9, 32'd2);
        apply(4'd5, 32'd7, 32'hfffffffe);
        apply(4'd5, 32'd1234, 32'd0);
        apply(4'd6, 32'd4, 32'h100);
        apply(4'd6, 32'd4, 32'd0);
        apply(4'd8, 32'd0, 32'd0);
        apply(4'd8, 32'd0, 32'h80000000);
        apply(4'd7, 32'hf0f0f0f0, 32'h0ff00ff0);
        apply(4'd9, 32'hf0f0f0f0, 32'h0ff00ff0);
        apply(4'd10, 32'd0, 32'hdeadbeef);
        apply(4'd10, 32'd0, 32'd0);
        apply(4'd11, 32'h12345678, 32'd0);
        apply(4'd11, 32'h12345678, 32'hffffffff);
        for (int s = 12; s < 16; s++) apply(4'(s), 32'hffffffff, 32'hffffffff);

        // R13: change inputs mid-cycle, no clock edge before sampling
        @(posedge clk);
        #2ns;
        op_sel = 4'd9;
        op_a   = 32'h00000f00;
        op_b   = 32'h000000f0;
        #1ns;
        check("R13", result, 32'h00000ff0, err_code, 4'd0);
        op_b = 32'd0;
        op_sel = 4'd5;
        #1ns;
        check("R13", result, 32'd0, err_code, 4'd3);

        for (int i = 0; i < 600; i++) begin
            apply(4'($urandom % 16), pick_operand(), pick_operand());
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #100us;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung, expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule